// File: doc/BRIEF.md
# Vectored Interrupt Arbiter

This block gathers interrupt events from a fixed set of peripheral sources and hands one of them at a time to a simple processor core. Every source has a one-bit pending flag. A one-cycle pulse on the source's request line sets the flag. A per-source mask register and a global enable bit decide whether a pending flag may be serviced. The core reports each finished instruction on a boundary strobe. At such a boundary the arbiter may accept the lowest-numbered pending, unmasked source. It then runs a fixed entry sequence that ends in a jump to that source's vector.

Accepting an interrupt clears the global enable, so handlers never nest. A return strobe from the core sets the enable again. Exactly one more instruction boundary must then pass before the next entry can start. Requests that arrive while a handler runs stay pending and are taken after the return. Two events from the same source that arrive before its flag is cleared merge into one service.

Top module: `irq_vector_arb`

## Requirements
- R1: After reset the global enable is 0, all mask bits are 0, all pending flags are 0, and `take_o`, `busy_o` and `jump_o` are 0.
- R2: A 1 on bit k of `irq_i` sets `pend_o[k]` in the following cycle, whatever the value of mask bit k.
- R3: An entry is accepted only in a cycle where `boundary_i` is 1, the global enable is 1, no entry is running, the post-return hold is clear, and at least one pending flag has its mask bit set.
- R4: When several pending, unmasked sources are eligible, `vec_o` gives the lowest index among them.
- R5: In the first cycle after acceptance, `take_o` is 1 for exactly one cycle, `gie_o` is 0, and the chosen pending flag reads 0 unless a new event for that source came in on the accepting cycle.
- R6: The entry sequence keeps `busy_o` high for 7 cycles, counted from the take cycle. `jump_o` is 1 only in the 7th cycle. `boundary_i` has no effect while `busy_o` is high.
- R7: While the global enable is 0, pending flags stay set and no entry is taken at a boundary.
- R8: Two events from one source that arrive before its flag is cleared produce a single entry. After that entry the flag reads 0.
- R9: An event that arrives after the flag was cleared at entry sets the flag again. That event is served after the running handler returns.
- R10: A 1 on bit k of `pend_clr_i` clears `pend_o[k]`. If `irq_i[k]` is 1 in the same cycle, the flag ends up 1.
- R11: `reti_i` sets the global enable in the next cycle. The first boundary after the return takes no entry. A later boundary may take one.
- R12: A masked source keeps its pending flag. Once its mask bit is written to 1, it is serviced at the next eligible boundary.
- R13: A write with `gie_we_i` loads the global enable from `gie_wdata_i`. A write with `mask_we_i` loads all mask bits from `mask_wdata_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | NSRC | Request pulses, one bit per source |
| mask_we_i | input | 1 | Mask register write strobe |
| mask_wdata_i | input | NSRC | New mask value, 1 = source allowed |
| gie_we_i | input | 1 | Global enable write strobe |
| gie_wdata_i | input | 1 | New global enable value |
| pend_clr_i | input | NSRC | Write-one-to-clear for pending flags |
| boundary_i | input | 1 | Instruction-finished strobe from the core |
| reti_i | input | 1 | Return-from-handler strobe |
| take_o | output | 1 | One-cycle pulse in the first entry cycle |
| vec_o | output | VEC_W | Index of the accepted source |
| busy_o | output | 1 | Entry sequence in progress |
| jump_o | output | 1 | Last entry cycle: fetch from the vector |
| gie_o | output | 1 | Global enable state |
| pend_o | output | NSRC | Pending flags |

## Verification
The selection logic is tested first with two sources raised together. This shows whether the lowest index wins (R4). It then checks that the higher one waits through the return and the hold boundary (R11). Repeated pulses from one source before entry are compared with one pulse that lands inside the entry sequence. The first case must give one service and the second must give two, which separates merging from re-arming (R8, R9). The tests also cover a masked source, a disabled global enable, and a clear that collides with a set. Each of these shows that recording and servicing are kept apart (R7, R10, R12).

// File: rtl/irq_vector_arb.sv
module irq_vector_arb #(
  parameter int NSRC      = 8,
  parameter int ENTRY_CYC = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NSRC-1:0]          irq_i,
  input  logic                     mask_we_i,
  input  logic [NSRC-1:0]          mask_wdata_i,
  input  logic                     gie_we_i,
  input  logic                     gie_wdata_i,
  input  logic [NSRC-1:0]          pend_clr_i,
  input  logic                     boundary_i,
  input  logic                     reti_i,
  output logic                     take_o,
  output logic [$clog2(NSRC)-1:0]  vec_o,
  output logic                     busy_o,
  output logic                     jump_o,
  output logic                     gie_o,
  output logic [NSRC-1:0]          pend_o
);
  localparam int VEC_W = $clog2(NSRC);
  localparam int CNT_W = $clog2(ENTRY_CYC + 1);

  logic [NSRC-1:0]  pend_q, mask_q, ready, sel_oh;
  logic [VEC_W-1:0] sel_idx, vec_q;
  logic [CNT_W-1:0] cnt_q;
  logic             gie_q, hold_q, accept;

  assign ready  = pend_q & mask_q;
  assign busy_o = (cnt_q != '0);
  assign take_o = (cnt_q == CNT_W'(1));
  assign jump_o = (cnt_q == CNT_W'(ENTRY_CYC));
  assign vec_o  = vec_q;
  assign gie_o  = gie_q;
  assign pend_o = pend_q;
  assign accept = boundary_i && gie_q && !hold_q && !busy_o && (|ready);

  always_comb begin
    sel_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (ready[i]) sel_idx = VEC_W'(i);
  end

  assign sel_oh = accept ? (NSRC'(1) << sel_idx) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= '0;
      gie_q  <= 1'b0;
      hold_q <= 1'b0;
      cnt_q  <= '0;
      vec_q  <= '0;
    end else begin
      pend_q <= (pend_q & ~pend_clr_i & ~sel_oh) | irq_i;
      if (mask_we_i) mask_q <= mask_wdata_i;

      if (accept)         gie_q <= 1'b0;
      else if (gie_we_i)  gie_q <= gie_wdata_i;
      else if (reti_i)    gie_q <= 1'b1;

      if (reti_i)                      hold_q <= 1'b1;
      else if (boundary_i && !busy_o)  hold_q <= 1'b0;

      if (accept) begin
        cnt_q <= CNT_W'(1);
        vec_q <= sel_idx;
      end else if (busy_o) begin
        cnt_q <= (cnt_q == CNT_W'(ENTRY_CYC)) ? '0 : cnt_q + CNT_W'(1);
      end
    end
  end

  p_take_at_boundary_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> ($past(boundary_i) && $past(gie_o) && !$past(busy_o)));

  p_lowest_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (($past(pend_o & mask_q) & ((NSRC'(1) << vec_o) - NSRC'(1))) == '0));

  p_take_clears_gie_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> !gie_o);

  p_take_clears_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (!pend_o[vec_o] || (($past(irq_i) >> vec_o) & NSRC'(1)) != '0));

  p_take_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> !take_o);

  p_busy_starts_with_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> take_o);

  p_jump_inside_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    jump_o |-> busy_o);

  p_jump_ends_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    jump_o |=> (!busy_o || take_o));

  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_i) |=> ((pend_o & $past(irq_i)) == $past(irq_i)));

  p_reti_sets_gie_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_i && !gie_we_i && !accept) |=> gie_o);

  p_no_take_gie_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!gie_o && !gie_we_i && !reti_i) |=> !take_o);
endmodule

// File: tb/tb_irq_vector_arb.sv
module tb_irq_vector_arb;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 8;
  localparam int VEC_W = 3;

  logic clk = 0, rst_n = 0;
  logic [NSRC-1:0] irq_i = '0, mask_wdata_i = '0, pend_clr_i = '0;
  logic mask_we_i = 0, gie_we_i = 0, gie_wdata_i = 0, boundary_i = 0, reti_i = 0;
  logic take_o, busy_o, jump_o, gie_o;
  logic [VEC_W-1:0] vec_o;
  logic [NSRC-1:0] pend_o;
  int checks = 0, errors = 0;
  bit done = 0;

  irq_vector_arb #(.NSRC(NSRC), .ENTRY_CYC(7)) dut (
    .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .mask_we_i(mask_we_i),
    .mask_wdata_i(mask_wdata_i), .gie_we_i(gie_we_i), .gie_wdata_i(gie_wdata_i),
    .pend_clr_i(pend_clr_i), .boundary_i(boundary_i), .reti_i(reti_i),
    .take_o(take_o), .vec_o(vec_o), .busy_o(busy_o), .jump_o(jump_o),
    .gie_o(gie_o), .pend_o(pend_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    irq_i = '0; pend_clr_i = '0; mask_we_i = 0; gie_we_i = 0;
    boundary_i = 0; reti_i = 0;
  endtask

  task automatic set_gie(bit v);
    gie_we_i = 1; gie_wdata_i = v; step();
  endtask

  task automatic set_mask(logic [NSRC-1:0] m);
    mask_we_i = 1; mask_wdata_i = m; step();
  endtask

  task automatic pulse_irq(logic [NSRC-1:0] m);
    irq_i = m; step();
  endtask

  task automatic boundary_no_take(string req);
    boundary_i = 1; step();
    chk(req, "take after boundary", take_o, 0);
    chk(req, "busy after boundary", busy_o, 0);
  endtask

  task automatic entry(string req, int vec, logic [NSRC-1:0] pend_exp);
    boundary_i = 1; step();
    chk(req, "take", take_o, 1);
    chk(req, "vector", vec_o, vec);
    chk("R5", "gie after take", gie_o, 0);
    chk("R5", "pend after take", pend_o, pend_exp);
    for (int c = 1; c <= 7; c++) begin
      if (c > 1) chk("R6", "take only once", take_o, 0);
      chk("R6", "busy in entry", busy_o, 1);
      chk("R6", "jump timing", jump_o, (c == 7) ? 1 : 0);
      boundary_i = 1; step();
    end
    chk("R6", "busy after entry", busy_o, 0);
    chk("R6", "no re-take from ignored boundary", take_o, 0);
  endtask

  task automatic do_return();
    reti_i = 1; step();
    chk("R11", "gie after return", gie_o, 1);
  endtask

  task automatic t_reset();
    chk("R1", "gie", gie_o, 0);
    chk("R1", "pend", pend_o, 0);
    chk("R1", "take", take_o, 0);
    chk("R1", "busy", busy_o, 0);
    chk("R1", "jump", jump_o, 0);
    pulse_irq(8'h01);
    set_gie(1);
    boundary_no_take("R1");
    chk("R1", "masked flag kept", pend_o, 8'h01);
    pend_clr_i = 8'h01; step();
    set_gie(0);
  endtask

  task automatic t_priority();
    set_mask(8'hFF);
    pulse_irq(8'h28);
    chk("R2", "pend from pulses", pend_o, 8'h28);
    boundary_no_take("R7");
    chk("R7", "pend held while disabled", pend_o, 8'h28);
    set_gie(1);
    chk("R13", "gie write", gie_o, 1);
    entry("R4", 3, 8'h20);
    boundary_no_take("R7");
    do_return();
    boundary_no_take("R11");
    entry("R11", 5, 8'h00);
    do_return();
    boundary_no_take("R11");
  endtask

  task automatic t_merge();
    pulse_irq(8'h04);
    pulse_irq(8'h04);
    entry("R8", 2, 8'h00);
    chk("R8", "merged flag clear", pend_o, 8'h00);
    do_return();
    boundary_no_take("R8");
    boundary_no_take("R8");
  endtask

  task automatic t_rearm();
    boundary_i = 1; step();
    chk("R9", "first take", take_o, 0);
    pulse_irq(8'h04);
    boundary_i = 1; step();
    chk("R9", "take", take_o, 1);
    chk("R9", "flag cleared", pend_o, 8'h00);
    pulse_irq(8'h04);
    chk("R9", "re-armed during entry", pend_o, 8'h04);
    for (int c = 0; c < 6; c++) step();
    chk("R9", "entry over", busy_o, 0);
    boundary_no_take("R9");
    do_return();
    boundary_no_take("R9");
    entry("R9", 2, 8'h00);
    do_return();
    boundary_no_take("R9");
  endtask

  task automatic t_clear();
    set_gie(0);
    pulse_irq(8'h40);
    chk("R10", "set", pend_o, 8'h40);
    pend_clr_i = 8'h40; step();
    chk("R10", "w1c", pend_o, 8'h00);
    pulse_irq(8'h40);
    irq_i = 8'h40; pend_clr_i = 8'h40; step();
    chk("R10", "set wins over clear", pend_o, 8'h40);
    pend_clr_i = 8'h40; step();
    chk("R10", "clear again", pend_o, 8'h00);
  endtask

  task automatic t_mask();
    set_mask(8'hFD);
    pulse_irq(8'h02);
    set_gie(1);
    boundary_no_take("R12");
    boundary_no_take("R12");
    chk("R12", "masked flag kept", pend_o, 8'h02);
    set_mask(8'hFF);
    entry("R12", 1, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    step();
    t_reset();
    t_priority();
    t_merge();
    t_rearm();
    t_clear();
    t_mask();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule